// File: doc/BRIEF.md
# SIMD Modified Immediate Expander

This unit turns the short immediate carried by a one-register-and-immediate vector instruction into the full 64-bit constant that the vector operation consumes. Three raw instruction fields are assembled into one byte. A 4-bit shape selector and a 1-bit invert selector then choose how that byte is expanded. The choices are:

- placement at one of four byte offsets;
- halfword placement;
- a shifted form with ones filled in below;
- byte replication;
- a per-bit byte mask;
- a compact single-precision float pattern.

In every case except one, a 32-bit word is formed and copied into both halves of the result.

The unit is purely combinational up to an optional output register, selected by a parameter (on by default). When that register is present, the constant and the invalid flag appear one clock after the inputs, and a synchronous active-high reset clears them. The one unallocated selector combination raises the invalid flag and forces the constant to zero. Which operation consumes the constant is decided outside this block.

Top module: `simd_imm_expand`

## Requirements
- R1: The working byte is assembled with `imm_top_i` as bit 7, `imm_mid_i[2:0]` as bits 6:4 and `imm_low_i[3:0]` as bits 3:0.
- R2: For shape values 0 to 7, the 32-bit word holds the byte at bit offset 8*(shape>>1). All other bits are zero.
- R3: Shape values 8 and 9 put the byte at bits 7:0 and 23:16 of the word. Shape values 10 and 11 put it at bits 15:8 and 31:24. All other bits are zero.
- R4: Shape 12 gives the word (byte<<8)|0x000000FF. Shape 13 gives (byte<<16)|0x0000FFFF.
- R5: Shape 14 with invert=0 repeats the byte in all four bytes of the word.
- R6: Shape 14 with invert=1 yields a 64-bit result whose byte n (bits 8n+7:8n) is 0xFF when byte bit n is 1 and 0x00 otherwise. This result is never inverted, and its two 32-bit halves may differ.
- R7: Shape 15 with invert=0 builds the word from the byte as follows: bit 31 = byte[7]; bits 24:19 = byte[5:0]; when byte[6]=1, bits 29:25 are all ones and bit 30 is 0; when byte[6]=0, bit 30 is 1 and bits 29:25 are 0; all other bits are 0.
- R8: With invert=1 and any shape other than 14 and 15, the word is the bitwise complement of the invert=0 word.
- R9: For every case other than shape 14 with invert=1, `const_o[63:32]` equals `const_o[31:0]`.
- R10: Shape 15 with invert=1 sets `bad_o` to 1 and `const_o` to zero. Every other combination keeps `bad_o` at 0.
- R11: An all-zero byte has no special handling. For example, shape 6 gives 0 and shape 12 gives 0x000000FF.
- R12: With `OUT_REG`=1, `const_o` and `bad_o` follow the inputs with one clock of latency, and a synchronous active-high `rst` clears both to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| imm_top_i | input | 1 | Byte bit 7 |
| imm_mid_i | input | 3 | Byte bits 6:4 |
| imm_low_i | input | 4 | Byte bits 3:0 |
| shape_i | input | 4 | Expansion shape selector |
| inv_i | input | 1 | Invert selector |
| const_o | output | 64 | Expanded vector constant |
| bad_o | output | 1 | Unallocated encoding flag |

## Verification
Every cycle, the assertions check the following:

- the halves of the constant match outside the byte-mask case;
- an unallocated encoding always yields a zero constant;
- the number of ones in the byte mask is eight times the number of set byte bits;
- the float pattern keeps bits 30 and 29 complementary;
- the output register delays the unregistered value by exactly one cycle.

Only the bench's scenarios can show that each shape places the byte at the right bits, that inversion applies where it should, and that the field assembly order is correct. To do this, the bench sweeps all 32 shape and invert pairs over sampled bytes, including zero. It also applies reset in the middle of a run.

// File: rtl/simd_imm_pkg.sv
package simd_imm_pkg;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 32;
  localparam int CONST_W = 64;
  localparam int SHAPE_W = 4;

  localparam logic [SHAPE_W-1:0] SHAPE_MASK  = 4'd14;
  localparam logic [SHAPE_W-1:0] SHAPE_FLOAT = 4'd15;
endpackage

// File: rtl/simd_imm_word.sv
module simd_imm_word
  import simd_imm_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [BYTE_W-1:0]   byte_i,
  input  logic [SHAPE_W-1:0]  shape_i,
  output logic [WORD_W-1:0]   word_o
);
  localparam int ZB = BYTE_W;

  logic [WORD_W-1:0] fp_word;
  assign fp_word = {byte_i[7], ~byte_i[6], {5{byte_i[6]}}, byte_i[5:0], 19'b0};

  always_comb begin
    case (shape_i[3:1])
      3'd0: word_o = {{(3*ZB){1'b0}}, byte_i};
      3'd1: word_o = {{(2*ZB){1'b0}}, byte_i, {ZB{1'b0}}};
      3'd2: word_o = {{ZB{1'b0}}, byte_i, {(2*ZB){1'b0}}};
      3'd3: word_o = {byte_i, {(3*ZB){1'b0}}};
      3'd4: word_o = {{ZB{1'b0}}, byte_i, {ZB{1'b0}}, byte_i};
      3'd5: word_o = {byte_i, {ZB{1'b0}}, byte_i, {ZB{1'b0}}};
      3'd6: word_o = shape_i[0] ? {{ZB{1'b0}}, byte_i, {(2*ZB){1'b1}}}
                                : {{(2*ZB){1'b0}}, byte_i, {ZB{1'b1}}};
      default: word_o = shape_i[0] ? fp_word : {4{byte_i}};
    endcase
  end

  AST_FLOAT_EXP: assert property (@(posedge clk) disable iff (rst)
    (shape_i == SHAPE_FLOAT) |-> ((word_o[30] != word_o[29]) && (word_o[25] == word_o[29]))); // R7
endmodule

// File: rtl/simd_imm_mask.sv
module simd_imm_mask
  import simd_imm_pkg::*;
#(
  parameter int LANES = CONST_W / BYTE_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [LANES-1:0]          bits_i,
  output logic [LANES*BYTE_W-1:0]   mask_o
);
  for (genvar n = 0; n < LANES; n++) begin : g_lane
    assign mask_o[n*BYTE_W +: BYTE_W] = {BYTE_W{bits_i[n]}};
  end

  AST_MASK_POP: assert property (@(posedge clk) disable iff (rst)
    $countones(mask_o) == BYTE_W * $countones(bits_i)); // R6
endmodule

// File: rtl/simd_imm_stage.sv
module simd_imm_stage #(
  parameter int W       = 65,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (OUT_REG) begin : g_reg
    logic armed;
    always_ff @(posedge clk) begin
      if (rst) begin
        q_o   <= '0;
        armed <= 1'b0;
      end else begin
        q_o   <= d_i;
        armed <= 1'b1;
      end
    end

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      armed |-> (q_o == $past(d_i))); // R12
  end else begin : g_wire
    assign q_o = d_i;
  end
endmodule

// File: rtl/simd_imm_expand.sv
module simd_imm_expand
  import simd_imm_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               imm_top_i,
  input  logic [2:0]         imm_mid_i,
  input  logic [3:0]         imm_low_i,
  input  logic [SHAPE_W-1:0] shape_i,
  input  logic               inv_i,
  output logic [CONST_W-1:0] const_o,
  output logic               bad_o
);
  localparam int LANES = CONST_W / BYTE_W;
  localparam int PIPE_W = CONST_W + 1;

  logic [BYTE_W-1:0]  byte_c;
  logic [WORD_W-1:0]  word_c;
  logic [CONST_W-1:0] mask_c;
  logic [CONST_W-1:0] const_c;
  logic               bad_c;
  logic               sel_mask;
  logic [PIPE_W-1:0]  pipe_q;

  assign byte_c = {imm_top_i, imm_mid_i, imm_low_i};

  simd_imm_word u_word (
    .clk     (clk),
    .rst     (rst),
    .byte_i  (byte_c),
    .shape_i (shape_i),
    .word_o  (word_c)
  );

  simd_imm_mask #(.LANES(LANES)) u_mask (
    .clk    (clk),
    .rst    (rst),
    .bits_i (byte_c),
    .mask_o (mask_c)
  );

  assign sel_mask = (shape_i == SHAPE_MASK) && inv_i;
  assign bad_c    = (shape_i == SHAPE_FLOAT) && inv_i;

  always_comb begin
    if (bad_c)
      const_c = '0;
    else if (sel_mask)
      const_c = mask_c;
    else if (inv_i)
      const_c = {2{~word_c}};
    else
      const_c = {2{word_c}};
  end

  simd_imm_stage #(.W(PIPE_W), .OUT_REG(OUT_REG)) u_stage (
    .clk (clk),
    .rst (rst),
    .d_i ({bad_c, const_c}),
    .q_o (pipe_q)
  );

  assign bad_o   = pipe_q[CONST_W];
  assign const_o = pipe_q[CONST_W-1:0];

  AST_HALVES_MATCH: assert property (@(posedge clk) disable iff (rst)
    !sel_mask |-> (const_c[CONST_W-1:WORD_W] == const_c[WORD_W-1:0])); // R9
  AST_BAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    bad_c |-> (const_c == '0)); // R10
  AST_BAD_ONLY_FLOAT: assert property (@(posedge clk) disable iff (rst)
    bad_c |-> (word_c[30] != word_c[29])); // R10
endmodule

// File: tb/sim_simd_imm_expand.sv
module sim_simd_imm_expand;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        top_b = 1'b0;
  logic [2:0]  mid_b = '0;
  logic [3:0]  low_b = '0;
  logic [3:0]  shape = '0;
  logic        inv = 1'b0;
  logic [63:0] cst;
  logic        bad;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  simd_imm_expand #(.OUT_REG(1'b1)) u0 (
    .clk(clk), .rst(rst),
    .imm_top_i(top_b), .imm_mid_i(mid_b), .imm_low_i(low_b),
    .shape_i(shape), .inv_i(inv),
    .const_o(cst), .bad_o(bad)
  );

  // vector: {byte[7:0], shape[3:0], inv, bad, const[63:0]}
  localparam int NV = 13;
  localparam logic [77:0] VEC [NV] = '{
    {8'hA5, 4'd0,  1'b0, 1'b0, 64'h000000A5_000000A5},
    {8'hA5, 4'd2,  1'b1, 1'b0, 64'hFFFF5AFF_FFFF5AFF},
    {8'h3C, 4'd8,  1'b0, 1'b0, 64'h003C003C_003C003C},
    {8'h3C, 4'd10, 1'b0, 1'b0, 64'h3C003C00_3C003C00},
    {8'h12, 4'd12, 1'b0, 1'b0, 64'h000012FF_000012FF},
    {8'h12, 4'd13, 1'b1, 1'b0, 64'hFFED0000_FFED0000},
    {8'h81, 4'd14, 1'b0, 1'b0, 64'h81818181_81818181},
    {8'h81, 4'd14, 1'b1, 1'b0, 64'hFF000000_000000FF},
    {8'h70, 4'd15, 1'b0, 1'b0, 64'h3F800000_3F800000},
    {8'h00, 4'd6,  1'b0, 1'b0, 64'h00000000_00000000},
    {8'h00, 4'd12, 1'b0, 1'b0, 64'h000000FF_000000FF},
    {8'h80, 4'd15, 1'b1, 1'b1, 64'h00000000_00000000},
    {8'h80, 4'd15, 1'b0, 1'b0, 64'hC0000000_C0000000}
  };

  function automatic logic [64:0] model(input logic [7:0] b, input logic [3:0] s, input logic v);
    logic [31:0] w;
    logic [63:0] m;
    if (s == 4'd15 && v) return {1'b1, 64'd0};
    if (s == 4'd14 && v) begin
      m = '0;
      for (int n = 0; n < 8; n++) if (b[n]) m[n*8 +: 8] = 8'hFF;
      return {1'b0, m};
    end
    case (s)
      4'd0, 4'd1:   w = 32'(b);
      4'd2, 4'd3:   w = 32'(b) << 8;
      4'd4, 4'd5:   w = 32'(b) << 16;
      4'd6, 4'd7:   w = 32'(b) << 24;
      4'd8, 4'd9:   w = 32'(b) | (32'(b) << 16);
      4'd10, 4'd11: w = (32'(b) << 8) | (32'(b) << 24);
      4'd12:        w = (32'(b) << 8) | 32'hFF;
      4'd13:        w = (32'(b) << 16) | 32'hFFFF;
      4'd14:        w = {b, b, b, b};
      default: begin
        w = 32'd0;
        w[31] = b[7];
        w[24:19] = b[5:0];
        if (b[6]) w[29:25] = 5'h1F; else w[30] = 1'b1;
      end
    endcase
    if (v) w = ~w;
    return {1'b0, w, w};
  endfunction

  function automatic string tag_of(input logic [3:0] s, input logic v);
    if (s == 4'd15 && v) return "R10";
    if (s == 4'd14 && v) return "R6";
    if (v && s != 4'd14) return "R8";
    if (s < 4'd8) return "R2";
    if (s < 4'd12) return "R3";
    if (s < 4'd14) return "R4";
    if (s == 4'd14) return "R5";
    return "R7";
  endfunction

  task automatic drive(input logic [7:0] b, input logic [3:0] s, input logic v);
    @(negedge clk);
    top_b = b[7]; mid_b = b[6:4]; low_b = b[3:0]; shape = s; inv = v;
  endtask

  task automatic check(input string tag, input logic [64:0] exp);
    tests++;
    if ({bad, cst} !== exp) begin
      fails++;
      $display("FAIL %s: got bad=%0b const=%h, expected bad=%0b const=%h",
               tag, bad, cst, exp[64], exp[63:0]);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      finish_run();
    end
  end

  initial begin
    // reset state, R12
    repeat (3) @(negedge clk);
    check("R12 reset", 65'd0);
    @(negedge clk) rst = 1'b0;

    // table walk
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][77:70], VEC[i][69:66], VEC[i][65]);
      @(negedge clk);
      check(tag_of(VEC[i][69:66], VEC[i][65]), VEC[i][64:0]);
    end

    // R1 field order: distinct fields, shape 0
    drive(8'hD3, 4'd0, 1'b0);
    @(negedge clk);
    check("R1", {1'b0, 64'h000000D3_000000D3});

    // R11 zero byte with shifted and ones-filled shapes
    drive(8'h00, 4'd13, 1'b0);
    @(negedge clk);
    check("R11", {1'b0, 64'h0000FFFF_0000FFFF});

    // R9 halves match for a replicated case, read at ports
    drive(8'h5A, 4'd9, 1'b1);
    @(negedge clk);
    tests++;
    if (cst[63:32] !== cst[31:0]) begin
      fails++;
      $display("FAIL R9: got %h, expected %h", cst[63:32], cst[31:0]);
    end

    // R12 latency: output unchanged just after input change
    drive(8'hFF, 4'd0, 1'b0);
    @(negedge clk);
    drive(8'h01, 4'd6, 1'b0);
    #2;
    check("R12 hold", {1'b0, 64'h000000FF_000000FF});
    @(negedge clk);
    check("R12 update", {1'b0, 64'h01000000_01000000});

    // full sweep: all shapes, both invert values, sampled bytes
    for (int s = 0; s < 16; s++) begin
      for (int v = 0; v < 2; v++) begin
        for (int k = 0; k < 8; k++) begin
          logic [7:0] b;
          case (k)
            0: b = 8'h00; 1: b = 8'h01; 2: b = 8'h7F; 3: b = 8'h80;
            4: b = 8'hA5; 5: b = 8'hFF; 6: b = 8'h5A; default: b = 8'hC3;
          endcase
          drive(b, 4'(s), 1'(v));
          @(negedge clk);
          check(tag_of(4'(s), 1'(v)), model(b, 4'(s), 1'(v)));
        end
      end
    end

    // R12 synchronous reset mid-stream clears outputs
    drive(8'hFF, 4'd14, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R12 mid reset", 65'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R6 after reset", {1'b0, 64'hFFFFFFFF_FFFFFFFF});

    done = 1'b1;
    finish_run();
  end
endmodule